// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitized, active-low composite sync stream and finds the vertical interval in it. Each low pulse is measured with a counter that stands in for an analog integrator. A pulse whose low time reaches a broad-pulse threshold arms the detector. The vertical output is then started by a sync edge, not by the threshold crossing. It is normally started by the rising edge that ends the first broad pulse. If the vertical interval carries no serrations, a longer default timeout starts it while sync is still low. The output is ended by the rising edge of the second short pulse that follows the last broad pulse, so its width is set by the sync train itself.

At the moment vertical sync is asserted, the block samples a line-rate horizontal reference from an external window generator. That sample becomes the odd/even field flag. Because the field decision is taken only at that moment, extra or damaged equalizing pulses ahead of the vertical interval cannot disturb it. All thresholds are parameters in clock cycles, so one design covers any line rate.

Top module: `vsync_field_detector`

## Requirements
- R1: While reset is asserted (synchronous, active low), and on the cycle after it, `vsync_n` is 1 and `field_odd` is 0. This holds even if reset arrives during an active vertical pulse.
- R2: A sync low pulse lasting fewer than BROAD_TH sampled cycles never arms the detector. This covers horizontal sync pulses, equalizing pulses and a pulse of BROAD_TH-1 cycles, and `vsync_n` stays 1 through them.
- R3: After a low pulse reaches BROAD_TH cycles, `vsync_n` goes to 0 on the first cycle in which `csync_n` is sampled high again.
- R4: After vertical has started, `vsync_n` returns to 1 on the first high sample of the second short pulse (fewer than BROAD_TH low cycles) that follows the most recent broad pulse.
- R5: If `csync_n` stays low for DEF_TH sampled cycles after arming, `vsync_n` goes to 0 on that DEF_TH-th low sample. The end of the pulse still follows R4.
- R6: `field_odd` takes the value of `href` sampled in the cycle in which `vsync_n` falls (1 = odd, 0 = even). It holds that value at all other times.
- R7: Extra or lengthened pre-equalizing pulses, and any `href` activity before vertical starts, leave `field_odd` unchanged.
- R8: A broad pulse that arrives after one short post-equalizing pulse discards that partial count. Two further short pulses are then needed to end vertical.
- R9: A low pulse of exactly BROAD_TH cycles counts as broad and arms the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_n | input | 1 | Composite sync, active low, synchronous to clk |
| href | input | 1 | Line-rate horizontal reference from the window generator |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | Field flag: 1 odd, 0 even |

## Verification
The bench builds the block with BROAD_TH = 10, DEF_TH = 40 and POST_N = 2, on a half line of 32 cycles, with equalizing pulses of 2 cycles, broad pulses of 27 cycles and horizontal sync of 5 cycles. At these values a whole frame lasts only a few hundred cycles. Every output can therefore be compared on every cycle against values derived from the pulse lengths. This covers serrated and unserrated frames, both field parities, the BROAD_TH-1 and BROAD_TH pulse boundary, a broad pulse interrupting the post-equalizing count, and reset in the middle of vertical.

// File: rtl/vsd_pkg.sv
// Shared types for the vertical sync and field detector.
package vsd_pkg;
    // Vertical detector sequencing states.
    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,  // waiting for a broad pulse
        VS_ARMED  = 2'd1,  // broad pulse seen, waiting for its end or the timeout
        VS_ACTIVE = 2'd2   // vertical output asserted
    } vs_state_t;
endpackage

// File: rtl/vsd_low_integrator.sv
// Low-time integrator: counts sampled low cycles of the active-low composite
// sync input and flags the threshold crossings and the rising edge of every pulse.
// Assumes csync_n is already synchronous to clk. The counter saturates at DEF_TH.
module vsd_low_integrator #(
    parameter int BROAD_TH = 270,
    parameter int DEF_TH   = 1755
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic rise,        // csync_n sampled high after a low sample
    output logic broad_hit,   // BROAD_TH-th consecutive low sample
    output logic dflt_hit,    // DEF_TH-th consecutive low sample
    output logic long_pulse   // rise ending a pulse of at least BROAD_TH low cycles
);
    localparam int CW = $clog2(DEF_TH + 1);

    logic          cs_q;
    logic [CW-1:0] low_cnt;

    // Track previous sync level and accumulate low time of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            cs_q <= csync_n;
            if (csync_n)
                low_cnt <= '0;
            else if (low_cnt != CW'(DEF_TH))
                low_cnt <= low_cnt + CW'(1);
        end
    end

    // Decode edges and threshold crossings from the live sample and the count.
    always_comb begin
        rise       = csync_n && !cs_q;
        broad_hit  = !csync_n && (low_cnt == CW'(BROAD_TH - 1));
        dflt_hit   = !csync_n && (low_cnt == CW'(DEF_TH - 1));
        long_pulse = rise && (low_cnt >= CW'(BROAD_TH));
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= CW'(DEF_TH));
    assert_single_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(broad_hit && dflt_hit));
endmodule

// File: rtl/vsd_vert_seq.sv
// Vertical sequencer: arms on a broad pulse, asserts vertical on the next
// rising sync edge or on the default timeout, and releases it on the rising
// edge of the POST_N-th short pulse after the last broad pulse.
// Assumes the integrator's strobes are single-cycle and mutually consistent.
module vsd_vert_seq
    import vsd_pkg::*;
#(
    parameter int POST_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic broad_hit,
    input  logic dflt_hit,
    input  logic long_pulse,
    output logic start_stb,   // vertical starts this cycle
    output logic vsync_n
);
    localparam int PW = $clog2(POST_N + 1);

    vs_state_t     state;
    logic [PW-1:0] post_cnt;

    // Start condition: armed and either the pulse ended or the timeout expired.
    always_comb start_stb = (state == VS_ARMED) && (rise || dflt_hit);

    // Sequence the vertical interval and count short post-equalizing pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= VS_IDLE;
            post_cnt <= '0;
            vsync_n  <= 1'b1;
        end else begin
            case (state)
                VS_IDLE: begin
                    if (broad_hit) state <= VS_ARMED;
                end
                VS_ARMED: begin
                    if (start_stb) begin
                        state    <= VS_ACTIVE;
                        vsync_n  <= 1'b0;
                        post_cnt <= '0;
                    end
                end
                VS_ACTIVE: begin
                    if (broad_hit) begin
                        post_cnt <= '0;
                    end else if (rise && !long_pulse) begin
                        if (post_cnt == PW'(POST_N - 1)) begin
                            state    <= VS_IDLE;
                            vsync_n  <= 1'b1;
                            post_cnt <= '0;
                        end else begin
                            post_cnt <= post_cnt + PW'(1);
                        end
                    end
                end
                default: state <= VS_IDLE;
            endcase
        end
    end

    assert_start_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> $past(rise || dflt_hit));
    assert_end_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> $past(rise && !long_pulse));
    assert_arm_needs_broad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_IDLE && !broad_hit) |=> (state == VS_IDLE));
endmodule

// File: rtl/vsd_field_latch.sv
// Field latch: captures the horizontal reference when vertical starts.
// Assumes load is a single-cycle strobe aligned with the vertical start.
module vsd_field_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic href,
    output logic field_odd
);
    // Hold the field decision between vertical starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_odd <= 1'b0;
        else if (load)
            field_odd <= href;
    end
endmodule

// File: rtl/vsync_field_detector.sv
// Vertical sync and odd/even field detector for a digitized active-low
// composite sync stream. Thresholds are in clock cycles: BROAD_TH lies between
// equalizing and broad pulse widths, DEF_TH is the no-serration fallback.
module vsync_field_detector #(
    parameter int BROAD_TH = 270,
    parameter int DEF_TH   = 1755,
    parameter int POST_N   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic href,
    output logic vsync_n,
    output logic field_odd
);
    logic rise, broad_hit, dflt_hit, long_pulse, start_stb;

    vsd_low_integrator #(.BROAD_TH(BROAD_TH), .DEF_TH(DEF_TH)) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .csync_n    (csync_n),
        .rise       (rise),
        .broad_hit  (broad_hit),
        .dflt_hit   (dflt_hit),
        .long_pulse (long_pulse)
    );

    vsd_vert_seq #(.POST_N(POST_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .broad_hit  (broad_hit),
        .dflt_hit   (dflt_hit),
        .long_pulse (long_pulse),
        .start_stb  (start_stb),
        .vsync_n    (vsync_n)
    );

    vsd_field_latch u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_stb),
        .href      (href),
        .field_odd (field_odd)
    );

    assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(vsync_n) |-> $stable(field_odd));
    assert_field_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (field_odd == $past(href)));
endmodule

// File: tb/vsync_field_detector_test.sv
module vsync_field_detector_test;
    localparam int BROAD_TH = 10;
    localparam int DEF_TH   = 40;
    localparam int POST_N   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic href = 1'b0;
    logic vsync_n, field_odd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit ev = 1'b1;       // expected vsync_n
    bit ef = 1'b0;       // expected field_odd
    bit cur_odd = 1'b0;
    string ftag = "R6";

    always #2 clk = ~clk;

    vsync_field_detector #(.BROAD_TH(BROAD_TH), .DEF_TH(DEF_TH), .POST_N(POST_N)) uut (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .href(href),
        .vsync_n(vsync_n), .field_odd(field_odd));

    task automatic check(input string rq);
        checks++;
        if (vsync_n !== ev) begin
            errors++;
            $display("FAIL %s vsync_n actual %b expected %b at %0t", rq, vsync_n, ev, $time);
        end
        checks++;
        if (field_odd !== ef) begin
            errors++;
            $display("FAIL %s field_odd actual %b expected %b at %0t", ftag, field_odd, ef, $time);
        end
    endtask

    // One cycle: drive at negedge, let a posedge pass, come back to a negedge.
    task automatic step(input bit v, input bit hv);
        csync_n = v;
        href = hv;
        @(posedge clk);
        @(negedge clk);
    endtask

    // act: 0 none, 1 vertical starts at first high sample,
    //      2 vertical starts at DEF_TH-th low sample, 3 vertical ends at first high sample.
    task automatic seg(input int lo, input int hi, input int act, input bit hv, input string rq);
        for (int k = 1; k <= lo; k++) begin
            step(1'b0, hv);
            if (act == 2 && k == DEF_TH) begin ev = 1'b0; ef = cur_odd; end
            check(rq);
        end
        for (int k = 1; k <= hi; k++) begin
            step(1'b1, hv);
            if (k == 1 && act == 1) begin ev = 1'b0; ef = cur_odd; end
            if (k == 1 && act == 3) ev = 1'b1;
            check(rq);
        end
    endtask

    task automatic hlines(input int n);
        for (int i = 0; i < n; i++) seg(5, 59, 0, ~cur_odd, "R2");
    endtask

    // mode 0 serrated, 1 no serrations, 2 extra pre-eq, 3 broad after partial post
    task automatic frame(input bit odd, input int mode);
        cur_odd = odd;
        ftag = (mode == 2) ? "R7" : "R6";
        hlines(3);
        if (mode == 2) begin
            seg(2, 30, 0, odd, "R7");
            seg(BROAD_TH - 1, 32 - (BROAD_TH - 1), 0, odd, "R2");
            seg(2, 30, 0, odd, "R7");
        end
        for (int i = 0; i < 6; i++) seg(2, 30, 0, ~odd, "R2");
        if (mode == 1) begin
            seg(180, 12, 2, odd, "R5");
        end else begin
            seg(27, 5, 1, odd, "R3");
            for (int i = 0; i < 5; i++) seg(27, 5, 0, ~odd, "R3");
        end
        if (mode == 3) begin
            seg(2, 30, 0, ~odd, "R8");
            seg(27, 5, 0, ~odd, "R8");
            seg(2, 30, 0, ~odd, "R8");
            seg(2, 30, 3, ~odd, "R8");
        end else begin
            seg(2, 30, 0, ~odd, "R4");
            seg(2, 30, 3, ~odd, "R4");
        end
        for (int i = 0; i < 4; i++) seg(2, 30, 0, ~odd, "R4");
        hlines(3);
    endtask

    initial begin
        ev = 1'b1; ef = 1'b0;
        for (int i = 0; i < 3; i++) begin step(1'b1, 1'b1); check("R1"); end
        rst_n = 1'b1;
        step(1'b1, 1'b1); check("R1");

        frame(1'b1, 0);   // odd, serrated
        frame(1'b0, 0);   // even, serrated
        frame(1'b1, 1);   // odd, default timeout
        frame(1'b0, 2);   // even, extra pre-eq pulses
        frame(1'b1, 3);   // odd, broad interrupts post count

        // R9: a pulse of exactly BROAD_TH low cycles is broad
        cur_odd = 1'b0; ftag = "R6";
        hlines(2);
        seg(BROAD_TH, 32 - BROAD_TH, 1, 1'b0, "R9");
        seg(2, 30, 0, 1'b1, "R9");
        seg(2, 30, 3, 1'b1, "R9");
        hlines(2);

        // R1: reset in the middle of vertical
        cur_odd = 1'b1;
        for (int i = 0; i < 6; i++) seg(2, 30, 0, 1'b0, "R2");
        seg(27, 5, 1, 1'b1, "R3");
        seg(27, 5, 0, 1'b0, "R3");
        rst_n = 1'b0;
        ev = 1'b1; ef = 1'b0;
        step(1'b1, 1'b1); check("R1");
        step(1'b1, 1'b1); check("R1");
        rst_n = 1'b1;
        cur_odd = 1'b0;
        hlines(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule